// File: doc/BRIEF.md
# Floating-Point Register Stack File

This block holds the eight 80-bit data registers of a floating-point unit and presents them as a circular stack. Every operand is named by its distance from a 3-bit top pointer: slot ST(i) is physical register (top + i) mod 8. The pointer is exposed on its own port so the surrounding logic can place it in a status word. Data is carried as opaque 80-bit words. Bit 79 is the sign, bits 78:64 the exponent and bits 63:0 the significand, but the block never interprets them.

One command is accepted per clock. A push moves the pointer down and fills the new top. A pop presents the top value and then moves the pointer up. Reads and writes of any slot leave the pointer alone. An exchange swaps ST(0) with ST(i). An arithmetic write-back stores a result computed outside the block into ST(0) or ST(i), and may pop at the same time. A valid tag for each register lets the block refuse a push over a live value (overflow) and any use of an empty slot (underflow). A refused command leaves every register, tag and the pointer untouched.

Top module: `fpstk_file`

## Requirements
- R1: After reset the pointer `top_o` is 0 and every register is empty, so a pop issued straight after reset raises `unf_o`.
- R2: Push (`cmd_i`=1) decrements the pointer with wrap, so 0 becomes 7. It writes `wdata_i` into the new top and marks it valid. From the next cycle `opa_o` shows the pushed value.
- R3: A push whose target register (pointer minus one) is already valid raises `ovf_o` in that cycle and changes no register, tag or pointer.
- R4: Pop (`cmd_i`=2) shows ST(0) on `rdata_o` in the same cycle. At the clock it marks that register empty and increments the pointer with wrap, so 7 becomes 0.
- R5: `unf_o` is raised in the same cycle, and nothing changes, in four cases: a pop of an empty top; a read (`cmd_i`=3) of an empty ST(i); an exchange with ST(0) or ST(i) empty; an arithmetic write-back with ST(0) or ST(i) empty.
- R6: `idx_i` selects physical register (pointer + `idx_i`) mod 8 for `rdata_o` (other than during a pop) and for `opb_o`.
- R7: Read (`cmd_i`=3) leaves every register, tag and the pointer as they were.
- R8: Write (`cmd_i`=4) stores `wdata_i` into ST(`idx_i`) and marks it valid, empty or not, without moving the pointer. It never raises a flag.
- R9: Exchange (`cmd_i`=5) swaps the contents of ST(0) and ST(`idx_i`) in one clock, with the pointer unchanged.
- R10: `opa_o` always shows ST(0) and `opb_o` always shows ST(`idx_i`), combinationally in the same cycle.
- R11: Arithmetic write-back (`cmd_i`=6) stores `wdata_i` into ST(`idx_i`) when `wb_sti_i`=1, else into ST(0), and marks it valid. With `wb_pop_i`=1 the destination is taken from the pointer before the pop. The pop then empties the old top and increments the pointer; its clearing wins if the destination is that same register.
- R12: Command 0, and the unused code 7, change nothing and raise no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command: 0 none, 1 push, 2 pop, 3 read, 4 write, 5 exchange, 6 arithmetic write-back |
| idx_i | input | 3 | Stack-relative slot i |
| wdata_i | input | 80 | Value for push, write and write-back |
| wb_sti_i | input | 1 | Write-back goes to ST(i) when 1, ST(0) when 0 |
| wb_pop_i | input | 1 | Write-back also pops |
| rdata_o | output | 80 | ST(0) during a pop, otherwise ST(idx_i) |
| opa_o | output | 80 | ST(0) for the arithmetic unit |
| opb_o | output | 80 | ST(idx_i) for the arithmetic unit |
| top_o | output | 3 | Current top pointer |
| ovf_o | output | 1 | Stack overflow for the current command |
| unf_o | output | 1 | Stack underflow for the current command |

## Verification
The bench builds the block with its default of eight registers, so the pointer is 3 bits wide. Eight successive pushes therefore walk it through its wrap from 0 to 7 and fill the file exactly, and a ninth push hits a live register. A later run of pops carries the pointer across the 7-to-0 edge and empties the file. That opens all four underflow cases, followed by a non-pushing write into an empty slot.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    typedef struct packed {
        logic        sign;
        logic [14:0] expo;
        logic [63:0] mant;
    } xreg_t;

    localparam int XW = $bits(xreg_t);

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_PUSH  = 3'd1,
        CMD_POP   = 3'd2,
        CMD_READ  = 3'd3,
        CMD_WRITE = 3'd4,
        CMD_XCHG  = 3'd5,
        CMD_ARITH = 3'd6
    } stk_cmd_e;

    typedef enum logic [1:0] {
        SRC_IN  = 2'd0,
        SRC_ST0 = 2'd1,
        SRC_STI = 2'd2
    } wsrc_e;

endpackage

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
    import fpstk_pkg::*;
#(
    parameter int NREG = 8,
    localparam int PW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_cmd_e      cmd_i,
    input  logic [PW-1:0] idx_i,
    input  logic          wb_sti_i,
    input  logic          wb_pop_i,
    output logic [PW-1:0] top_o,
    output logic [PW-1:0] ptr_st0_o,
    output logic [PW-1:0] ptr_sti_o,
    output logic [PW-1:0] ptr_rd_o,
    output logic          we_a_o,
    output logic [PW-1:0] wa_a_o,
    output wsrc_e         src_a_o,
    output logic          we_b_o,
    output logic [PW-1:0] wa_b_o,
    output wsrc_e         src_b_o,
    output logic          ovf_o,
    output logic          unf_o
);

    typedef struct packed {
        logic [PW-1:0]   top;
        logic [NREG-1:0] tag;
    } ctl_t;

    ctl_t          cs_q, cs_d;
    logic [PW-1:0] p0, pi, pm;

    assign p0 = cs_q.top;
    assign pi = cs_q.top + idx_i;
    assign pm = cs_q.top - PW'(1);

    always_comb begin
        cs_d     = cs_q;
        we_a_o   = 1'b0;
        wa_a_o   = p0;
        src_a_o  = SRC_IN;
        we_b_o   = 1'b0;
        wa_b_o   = pi;
        src_b_o  = SRC_ST0;
        ovf_o    = 1'b0;
        unf_o    = 1'b0;
        ptr_rd_o = pi;
        case (cmd_i)
            CMD_PUSH: begin
                if (cs_q.tag[pm]) begin
                    ovf_o = 1'b1;
                end else begin
                    cs_d.top     = pm;
                    cs_d.tag[pm] = 1'b1;
                    we_a_o       = 1'b1;
                    wa_a_o       = pm;
                end
            end
            CMD_POP: begin
                ptr_rd_o = p0;
                if (!cs_q.tag[p0]) begin
                    unf_o = 1'b1;
                end else begin
                    cs_d.tag[p0] = 1'b0;
                    cs_d.top     = p0 + PW'(1);
                end
            end
            CMD_READ: begin
                unf_o = !cs_q.tag[pi];
            end
            CMD_WRITE: begin
                we_a_o       = 1'b1;
                wa_a_o       = pi;
                cs_d.tag[pi] = 1'b1;
            end
            CMD_XCHG: begin
                if (!cs_q.tag[p0] || !cs_q.tag[pi]) begin
                    unf_o = 1'b1;
                end else begin
                    we_a_o  = 1'b1;
                    wa_a_o  = p0;
                    src_a_o = SRC_STI;
                    we_b_o  = 1'b1;
                    wa_b_o  = pi;
                    src_b_o = SRC_ST0;
                end
            end
            CMD_ARITH: begin
                if (!cs_q.tag[p0] || !cs_q.tag[pi]) begin
                    unf_o = 1'b1;
                end else begin
                    we_a_o   = 1'b1;
                    wa_a_o   = wb_sti_i ? pi : p0;
                    cs_d.tag[wb_sti_i ? pi : p0] = 1'b1;
                    if (wb_pop_i) begin
                        cs_d.tag[p0] = 1'b0;
                        cs_d.top     = p0 + PW'(1);
                    end
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign top_o     = cs_q.top;
    assign ptr_st0_o = p0;
    assign ptr_sti_o = pi;

    a_r2_push_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PUSH && !ovf_o) |=> (cs_q.top == $past(cs_q.top) - PW'(1)));

    a_r2_push_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PUSH && !ovf_o) |=> cs_q.tag[cs_q.top]);

    a_r4_pop_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_POP && !unf_o) |=> (cs_q.top == $past(cs_q.top) + PW'(1)));

    a_r3_fault_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o || unf_o) |=> ($stable(cs_q.top) && $stable(cs_q.tag)));

    a_r7_top_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i inside {CMD_READ, CMD_WRITE, CMD_XCHG, CMD_NOP}) |=> $stable(cs_q.top));

    a_r11_pop_vacates: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ARITH && wb_pop_i && !unf_o) |=> !cs_q.tag[$past(cs_q.top)]);

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));

endmodule

// File: rtl/fpstk_bank.sv
module fpstk_bank
    import fpstk_pkg::*;
#(
    parameter int NREG = 8,
    parameter int NRD  = 3,
    localparam int PW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_a_i,
    input  logic [PW-1:0] wa_a_i,
    input  xreg_t         wd_a_i,
    input  logic          we_b_i,
    input  logic [PW-1:0] wa_b_i,
    input  xreg_t         wd_b_i,
    input  logic [PW-1:0] ra_i [NRD],
    output xreg_t         rd_o [NRD]
);

    xreg_t regs_q [NREG];
    xreg_t regs_d [NREG];

    always_comb begin
        for (int k = 0; k < NREG; k++) begin
            regs_d[k] = regs_q[k];
            if (we_a_i && wa_a_i == PW'(k)) begin
                regs_d[k] = wd_a_i;
            end else if (we_b_i && wa_b_i == PW'(k)) begin
                regs_d[k] = wd_b_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) begin
            if (!rst_n) begin
                regs_q[k] <= '0;
            end else begin
                regs_q[k] <= regs_d[k];
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_o[p] = regs_q[ra_i[p]];
    end

    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_a_i |=> (regs_q[$past(wa_a_i)] == $past(wd_a_i)));

    a_r9_second_port_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we_b_i && !(we_a_i && wa_a_i == wa_b_i)) |=> (regs_q[$past(wa_b_i)] == $past(wd_b_i)));

endmodule

// File: rtl/fpstk_file.sv
module fpstk_file
    import fpstk_pkg::*;
#(
    parameter int NREG = 8,
    localparam int PW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cmd_i,
    input  logic [PW-1:0] idx_i,
    input  logic [XW-1:0] wdata_i,
    input  logic          wb_sti_i,
    input  logic          wb_pop_i,
    output logic [XW-1:0] rdata_o,
    output logic [XW-1:0] opa_o,
    output logic [XW-1:0] opb_o,
    output logic [PW-1:0] top_o,
    output logic          ovf_o,
    output logic          unf_o
);

    localparam int NRD = 3;

    logic [PW-1:0] ptr_st0, ptr_sti, ptr_rd;
    logic          we_a, we_b;
    logic [PW-1:0] wa_a, wa_b;
    wsrc_e         src_a, src_b;
    xreg_t         wd_a, wd_b;
    logic [PW-1:0] ra [NRD];
    xreg_t         rd [NRD];

    initial begin
        a_pow2: assert ((1 << PW) == NREG);
    end

    fpstk_ctrl #(.NREG(NREG)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (stk_cmd_e'(cmd_i)),
        .idx_i     (idx_i),
        .wb_sti_i  (wb_sti_i),
        .wb_pop_i  (wb_pop_i),
        .top_o     (top_o),
        .ptr_st0_o (ptr_st0),
        .ptr_sti_o (ptr_sti),
        .ptr_rd_o  (ptr_rd),
        .we_a_o    (we_a),
        .wa_a_o    (wa_a),
        .src_a_o   (src_a),
        .we_b_o    (we_b),
        .wa_b_o    (wa_b),
        .src_b_o   (src_b),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o)
    );

    assign ra[0] = ptr_rd;
    assign ra[1] = ptr_st0;
    assign ra[2] = ptr_sti;

    function automatic xreg_t pick(wsrc_e s, xreg_t din, xreg_t s0, xreg_t si);
        case (s)
            SRC_ST0: return s0;
            SRC_STI: return si;
            default: return din;
        endcase
    endfunction

    always_comb begin
        wd_a = pick(src_a, xreg_t'(wdata_i), rd[1], rd[2]);
        wd_b = pick(src_b, xreg_t'(wdata_i), rd[1], rd[2]);
    end

    fpstk_bank #(.NREG(NREG), .NRD(NRD)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_a_i (we_a),
        .wa_a_i (wa_a),
        .wd_a_i (wd_a),
        .we_b_i (we_b),
        .wa_b_i (wa_b),
        .wd_b_i (wd_b),
        .ra_i   (ra),
        .rd_o   (rd)
    );

    assign rdata_o = rd[0];
    assign opa_o   = rd[1];
    assign opb_o   = rd[2];

endmodule

// File: tb/sim_fpstk_file.sv
module sim_fpstk_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [2:0]  idx = 3'd0;
    logic [79:0] wdata = '0;
    logic        wb_sti = 1'b0;
    logic        wb_pop = 1'b0;
    logic [79:0] rdata, opa, opb;
    logic [2:0]  top;
    logic        ovf, unf;

    always #5 clk = ~clk;

    fpstk_file u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .idx_i(idx), .wdata_i(wdata),
        .wb_sti_i(wb_sti), .wb_pop_i(wb_pop), .rdata_o(rdata), .opa_o(opa),
        .opb_o(opb), .top_o(top), .ovf_o(ovf), .unf_o(unf)
    );

    typedef struct {
        string       req;
        logic [2:0]  top;
        logic        ovf;
        logic        unf;
        logic [79:0] rd;
        logic [79:0] a;
        logic [79:0] b;
    } exp_t;

    exp_t        q[$];
    event        go;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    logic [79:0] mdl [8];
    logic [2:0]  mtop = 3'd0;
    logic [7:0]  mtag = 8'h00;

    function automatic logic [79:0] val(int k);
        return {k[0], 15'(16'h3FF0 + k), 64'hA5A5_0000_0000_0000 ^ 64'(k * 32'h0101_0107)};
    endfunction

    task automatic chk(string req, string what, logic [79:0] act, logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic op(logic [2:0] c, logic [2:0] i, logic [79:0] d, logic s, logic p, string req);
        exp_t        e;
        logic [2:0]  t0, ti, tm, dst;
        logic [79:0] tmp;
        @(negedge clk);
        cmd = c; idx = i; wdata = d; wb_sti = s; wb_pop = p;
        t0 = mtop; ti = mtop + i; tm = mtop - 3'd1;
        e.req = req;
        e.top = mtop;
        e.a   = mdl[t0];
        e.b   = mdl[ti];
        e.rd  = (c == 3'd2) ? mdl[t0] : mdl[ti];
        e.ovf = (c == 3'd1) && mtag[tm];
        e.unf = ((c == 3'd2) && !mtag[t0]) || ((c == 3'd3) && !mtag[ti]) ||
                ((c == 3'd5 || c == 3'd6) && (!mtag[t0] || !mtag[ti]));
        q.push_back(e);
        ->go;
        if (!e.ovf && !e.unf) begin
            case (c)
                3'd1: begin mtop = tm; mdl[tm] = d; mtag[tm] = 1'b1; end
                3'd2: begin mtag[t0] = 1'b0; mtop = t0 + 3'd1; end
                3'd4: begin mdl[ti] = d; mtag[ti] = 1'b1; end
                3'd5: begin tmp = mdl[t0]; mdl[t0] = mdl[ti]; mdl[ti] = tmp; end
                3'd6: begin
                    dst = s ? ti : t0;
                    mdl[dst] = d; mtag[dst] = 1'b1;
                    if (p) begin mtag[t0] = 1'b0; mtop = t0 + 3'd1; end
                end
                default: ;
            endcase
        end
    endtask

    initial begin
        forever begin
            exp_t e;
            @go;
            #1;
            while (q.size() > 0) begin
                e = q.pop_front();
                chk(e.req, "top", 80'(top), 80'(e.top));
                chk(e.req, "ovf", 80'(ovf), 80'(e.ovf));
                chk(e.req, "unf", 80'(unf), 80'(e.unf));
                chk(e.req, "rdata", rdata, e.rd);
                chk(e.req, "opa", opa, e.a);
                chk(e.req, "opb", opb, e.b);
            end
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) mdl[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        op(3'd0, 3'd0, '0, 0, 0, "R1_reset_state");
        op(3'd2, 3'd0, '0, 0, 0, "R1_pop_after_reset");
        for (int k = 1; k <= 8; k++) op(3'd1, 3'd0, val(k), 0, 0, "R2_push_wrap");
        op(3'd1, 3'd0, val(99), 0, 0, "R3_overflow");
        op(3'd0, 3'd0, '0, 0, 0, "R3_state_after_overflow");
        for (int k = 0; k < 8; k++) op(3'd3, 3'(k), '0, 0, 0, "R6_R10_slot_read");
        op(3'd3, 3'd4, '0, 0, 0, "R7_read_no_change");
        op(3'd5, 3'd3, '0, 0, 0, "R9_exchange");
        op(3'd3, 3'd3, '0, 0, 0, "R9_after_exchange");
        op(3'd7, 3'd2, val(55), 1, 1, "R12_unused_code");
        op(3'd6, 3'd2, val(40), 0, 0, "R11_writeback_st0");
        op(3'd6, 3'd1, val(41), 1, 1, "R11_writeback_sti_pop");
        op(3'd3, 3'd0, '0, 0, 0, "R11_after_pop");
        for (int k = 0; k < 7; k++) op(3'd2, 3'd0, '0, 0, 0, "R4_pop_wrap");
        op(3'd2, 3'd0, '0, 0, 0, "R5_pop_empty");
        op(3'd3, 3'd2, '0, 0, 0, "R5_read_empty");
        op(3'd5, 3'd1, '0, 0, 0, "R5_xchg_empty");
        op(3'd6, 3'd1, val(77), 1, 0, "R5_arith_empty");
        op(3'd4, 3'd5, val(60), 0, 0, "R8_write_empty");
        op(3'd3, 3'd5, '0, 0, 0, "R8_read_back");
        op(3'd1, 3'd0, val(61), 0, 0, "R2_push_after_write");
        op(3'd0, 3'd0, '0, 0, 0, "R12_idle");
        repeat (2) @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL ALL watchdog act=running exp=done");
            end
            wait (done);
        join_any
        #2;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule